// File: doc/BRIEF.md
# USB Clock and Reset Bring-up Sequencer

This block walks a USB host controller and its PHY out of reset after power-up. It runs entirely on the I/O clock. It drives the enable and reset lines in a fixed order: the controller interface clock, the PHY power-on reset, the host-clock divider, the PHY test-equipment reset, the 48/12 MHz divider, the PHY port reset and finally the host reset. Every timed gap is counted in I/O clock cycles. The cycle counts for one millisecond, one microsecond, ten nanoseconds and twenty nanoseconds are parameters, so the same RTL serves any I/O clock frequency.

Software-side users of the controller issue start and stop requests, and the block keeps a count of them. Only the request that takes the count from zero to one launches the bring-up. Stop requests lower the count and never put any reset back. When the host reset is already released at launch, the block goes straight to done without touching the PHY again. The reference clock rate, the crystal-or-external choice and the I/O-to-130 MHz clock ratio are decoded into the divider and reference-clock codes during the sequence.

Top module: `usb_rst_seq`

## Requirements
- R1: While reset is held and right after it, every output is 0, including `user_cnt`, `seq_done`, `host_div` and `rate_err`.
- R2: A start request with `user_cnt` = 0 raises `if_clk_en` at the next edge (cycle 0). It is the first output to change, and it stays high until block reset.
- R3: At cycle 2, `phy_por` rises. At that point the host reset, PHY port reset, both divider resets and both divider enables are all 0.
- R4: At cycle 3, `refclk_sel` becomes 0 for a crystal (`ref_xtal`=1) and 1 for an external clock. `refclk_div` becomes 0 for `ref_mhz`=12, 1 for 24 and 2 for 48. Any other rate gives 0 with `rate_err`=1; a valid rate gives `rate_err`=0.
- R5: At cycle 4, `host_div` is loaded from `io_ratio`: 0 maps to 1, 1 to 4 pass through unchanged, 5 maps to 4, 6 and 7 map to 6, 8 to 11 map to 8, and 12 or more map to 12.
- R6: `hdiv_en` rises at cycle 5 and `hdiv_rst_n` at cycle 6. `phy_por` falls DIV_WAIT cycles after `hdiv_rst_n` rises.
- R7: `phy_test_rst` rises CYC_1MS cycles after `phy_por` falls and stays high for CYC_10NS cycles. CYC_20NS cycles after it falls, `odiv_rst_n` rises.
- R8: `odiv_en` rises one cycle after `odiv_rst_n`. `phy_port_rst_n` rises DIV_WAIT cycles after `odiv_en`.
- R9: `host_rst_n` and `seq_done` rise together CYC_1US cycles after `phy_port_rst_n` rises.
- R10: `user_cnt` adds one for a start alone and subtracts one for a stop alone. It saturates at 0 and at its maximum (15 with CNT_W=4), and stays the same when start and stop arrive in the same cycle.
- R11: Once raised, `host_rst_n` and `seq_done` stay high until block reset. Stop requests, including one that brings the count to 0, change no reset, enable or done output.
- R12: A start request while the sequence is running only raises the count; the running sequence keeps its timing.
- R13: A start from count 0 after completion, with `host_rst_n` already high, changes no output other than `user_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_io | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | One-cycle start request from a user |
| stop_req | input | 1 | One-cycle stop request from a user |
| ref_mhz | input | RATE_W | Reference clock rate in MHz |
| ref_xtal | input | 1 | 1: crystal reference, 0: external clock |
| io_ratio | input | RATIO_W | I/O clock divided by 130 MHz, integer part |
| if_clk_en | output | 1 | Controller interface clock enable |
| phy_por | output | 1 | PHY power-on reset, active high |
| phy_test_rst | output | 1 | PHY test-equipment reset pulse |
| phy_port_rst_n | output | 1 | PHY port reset, 1 = released |
| hdiv_rst_n | output | 1 | Host-clock divider reset, 1 = released |
| hdiv_en | output | 1 | Host-clock divider enable |
| odiv_rst_n | output | 1 | 48/12 MHz divider reset, 1 = released |
| odiv_en | output | 1 | 48/12 MHz divider enable |
| host_rst_n | output | 1 | Host controller reset, 1 = released |
| refclk_sel | output | 1 | Reference select code |
| refclk_div | output | 2 | Reference divider code |
| host_div | output | 4 | Host-clock divide value |
| rate_err | output | 1 | Unsupported reference rate seen |
| seq_done | output | 1 | Bring-up complete |
| user_cnt | output | CNT_W | Outstanding start requests |

## Verification
Each step of the sequence is a separate state, so a wrong state or a wrong wait count shows up as a reset or enable edge that is early, late or missing. The bench catches it in the very cycle it occurs, because it predicts every output for every cycle since the start edge. A count that is off by one in the request counter shows up at `user_cnt` on the next edge. It also shows up later as a bring-up that is launched when it should not be, or one that never starts. A fault in a decode table shows up at the config outputs three or four cycles after the start and stays there, so it is checked on every following cycle.

// File: rtl/usbseq_pkg.sv
package usbseq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CHECK,
    ST_POR,
    ST_REF,
    ST_HDIV,
    ST_HEN,
    ST_HREL,
    ST_PORX,
    ST_TON,
    ST_TOFF,
    ST_OREL,
    ST_OEN,
    ST_PREL,
    ST_HOST,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    logic       sel;
    logic [1:0] div;
    logic       err;
  } refcfg_t;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // reference rate in MHz and source kind to select/divider codes
  function automatic refcfg_t decode_ref(input int unsigned mhz, input logic xtal);
    refcfg_t r;
    r.sel = ~xtal;
    r.err = 1'b0;
    case (mhz)
      32'd12:  r.div = 2'd0;
      32'd24:  r.div = 2'd1;
      32'd48:  r.div = 2'd2;
      default: begin
        r.div = 2'd0;
        r.err = 1'b1;
      end
    endcase
    return r;
  endfunction

  // I/O-to-130MHz ratio to host divider value
  function automatic logic [3:0] map_hdiv(input int unsigned ratio);
    logic [3:0] d;
    if (ratio == 0)       d = 4'd1;
    else if (ratio <= 4)  d = 4'(ratio);
    else if (ratio == 5)  d = 4'd4;
    else if (ratio <= 7)  d = 4'd6;
    else if (ratio <= 11) d = 4'd8;
    else                  d = 4'd12;
    return d;
  endfunction

endpackage

// File: rtl/usbseq_timer.sv
module usbseq_timer #(
  parameter int CW = 8
) (
  input  logic          clk_io,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/usbseq_users.sv
module usbseq_users #(
  parameter int CNT_W = 4
) (
  input  logic             clk_io,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             first
);

  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    case ({inc, dec})
      2'b10:   if (cnt_q != CMAX) cnt_d = cnt_q + 1'b1;
      2'b01:   if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt   = cnt_q;
  assign first = inc & ~dec & (cnt_q == '0);

endmodule

// File: rtl/usbseq_cfg.sv
module usbseq_cfg
  import usbseq_pkg::*;
#(
  parameter int RATE_W  = 8,
  parameter int RATIO_W = 8
) (
  input  logic               clk_io,
  input  logic               rst_n,
  input  logic               ld_ref,
  input  logic               ld_div,
  input  logic [RATE_W-1:0]  ref_mhz,
  input  logic               ref_xtal,
  input  logic [RATIO_W-1:0] io_ratio,
  output logic               refclk_sel,
  output logic [1:0]         refclk_div,
  output logic               rate_err,
  output logic [3:0]         host_div
);

  refcfg_t    ref_q;
  refcfg_t    ref_d;
  logic [3:0] div_q;
  logic [3:0] div_d;

  always_comb begin
    ref_d = ref_q;
    div_d = div_q;
    if (ld_ref) ref_d = decode_ref(32'(ref_mhz), ref_xtal);
    if (ld_div) div_d = map_hdiv(32'(io_ratio));
  end

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      div_q <= '0;
    end else begin
      ref_q <= ref_d;
      div_q <= div_d;
    end
  end

  assign refclk_sel = ref_q.sel;
  assign refclk_div = ref_q.div;
  assign rate_err   = ref_q.err;
  assign host_div   = div_q;

endmodule

// File: rtl/usb_rst_seq.sv
module usb_rst_seq
  import usbseq_pkg::*;
#(
  parameter int RATE_W   = 8,
  parameter int RATIO_W  = 8,
  parameter int CNT_W    = 4,
  parameter int DIV_WAIT = 64,
  parameter int CYC_1MS  = 600000,
  parameter int CYC_1US  = 600,
  parameter int CYC_10NS = 6,
  parameter int CYC_20NS = 12
) (
  input  logic               clk_io,
  input  logic               rst_n,
  input  logic               start_req,
  input  logic               stop_req,
  input  logic [RATE_W-1:0]  ref_mhz,
  input  logic               ref_xtal,
  input  logic [RATIO_W-1:0] io_ratio,
  output logic               if_clk_en,
  output logic               phy_por,
  output logic               phy_test_rst,
  output logic               phy_port_rst_n,
  output logic               hdiv_rst_n,
  output logic               hdiv_en,
  output logic               odiv_rst_n,
  output logic               odiv_en,
  output logic               host_rst_n,
  output logic               refclk_sel,
  output logic [1:0]         refclk_div,
  output logic [3:0]         host_div,
  output logic               rate_err,
  output logic               seq_done,
  output logic [CNT_W-1:0]   user_cnt
);

  localparam int unsigned MAXC = max_u(max_u(32'(DIV_WAIT), 32'(CYC_1MS)),
                                       max_u(32'(CYC_1US),
                                             max_u(32'(CYC_10NS), 32'(CYC_20NS))));
  localparam int CW = $clog2(MAXC + 1);

  localparam logic [CW-1:0] L_DIV  = CW'(DIV_WAIT - 1);
  localparam logic [CW-1:0] L_1MS  = CW'(CYC_1MS - 1);
  localparam logic [CW-1:0] L_1US  = CW'(CYC_1US - 1);
  localparam logic [CW-1:0] L_10NS = CW'(CYC_10NS - 1);
  localparam logic [CW-1:0] L_20NS = CW'(CYC_20NS - 1);

  seq_state_e    st_q, st_d;
  logic          trig;
  logic          tmr_zero;
  logic          tmr_ld;
  logic [CW-1:0] tmr_val;

  logic ev_ifen, ev_por, ev_ref, ev_hdiv, ev_hen, ev_hrel, ev_porx;
  logic ev_ton, ev_toff, ev_orel, ev_oen, ev_prel, ev_host;

  usbseq_users #(.CNT_W(CNT_W)) u_users (
    .clk_io (clk_io),
    .rst_n  (rst_n),
    .inc    (start_req),
    .dec    (stop_req),
    .cnt    (user_cnt),
    .first  (trig)
  );

  usbseq_timer #(.CW(CW)) u_timer (
    .clk_io   (clk_io),
    .rst_n    (rst_n),
    .load     (tmr_ld),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  usbseq_cfg #(.RATE_W(RATE_W), .RATIO_W(RATIO_W)) u_cfg (
    .clk_io     (clk_io),
    .rst_n      (rst_n),
    .ld_ref     (ev_ref),
    .ld_div     (ev_hdiv),
    .ref_mhz    (ref_mhz),
    .ref_xtal   (ref_xtal),
    .io_ratio   (io_ratio),
    .refclk_sel (refclk_sel),
    .refclk_div (refclk_div),
    .rate_err   (rate_err),
    .host_div   (host_div)
  );

  // next state, step events and wait loads
  always_comb begin
    st_d    = st_q;
    tmr_ld  = 1'b0;
    tmr_val = '0;
    ev_ifen = 1'b0; ev_por  = 1'b0; ev_ref  = 1'b0; ev_hdiv = 1'b0;
    ev_hen  = 1'b0; ev_hrel = 1'b0; ev_porx = 1'b0; ev_ton  = 1'b0;
    ev_toff = 1'b0; ev_orel = 1'b0; ev_oen  = 1'b0; ev_prel = 1'b0;
    ev_host = 1'b0;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (trig) begin
          ev_ifen = 1'b1;
          st_d    = ST_CHECK;
        end
      end
      ST_CHECK: st_d = host_rst_n ? ST_DONE : ST_POR;
      ST_POR: if (tmr_zero) begin
        ev_por = 1'b1;
        st_d   = ST_REF;
      end
      ST_REF: if (tmr_zero) begin
        ev_ref = 1'b1;
        st_d   = ST_HDIV;
      end
      ST_HDIV: if (tmr_zero) begin
        ev_hdiv = 1'b1;
        st_d    = ST_HEN;
      end
      ST_HEN: if (tmr_zero) begin
        ev_hen = 1'b1;
        st_d   = ST_HREL;
      end
      ST_HREL: if (tmr_zero) begin
        ev_hrel = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = L_DIV;
        st_d    = ST_PORX;
      end
      ST_PORX: if (tmr_zero) begin
        ev_porx = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = L_1MS;
        st_d    = ST_TON;
      end
      ST_TON: if (tmr_zero) begin
        ev_ton  = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = L_10NS;
        st_d    = ST_TOFF;
      end
      ST_TOFF: if (tmr_zero) begin
        ev_toff = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = L_20NS;
        st_d    = ST_OREL;
      end
      ST_OREL: if (tmr_zero) begin
        ev_orel = 1'b1;
        st_d    = ST_OEN;
      end
      ST_OEN: if (tmr_zero) begin
        ev_oen  = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = L_DIV;
        st_d    = ST_PREL;
      end
      ST_PREL: if (tmr_zero) begin
        ev_prel = 1'b1;
        tmr_ld  = 1'b1;
        tmr_val = L_1US;
        st_d    = ST_HOST;
      end
      ST_HOST: if (tmr_zero) begin
        ev_host = 1'b1;
        st_d    = ST_DONE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // reset and enable outputs, each written only on its own step events
  always_ff @(posedge clk_io or negedge rst_n) begin
    if (!rst_n) begin
      if_clk_en      <= 1'b0;
      phy_por        <= 1'b0;
      phy_test_rst   <= 1'b0;
      phy_port_rst_n <= 1'b0;
      hdiv_rst_n     <= 1'b0;
      hdiv_en        <= 1'b0;
      odiv_rst_n     <= 1'b0;
      odiv_en        <= 1'b0;
      host_rst_n     <= 1'b0;
      seq_done       <= 1'b0;
    end else begin
      if (ev_ifen) if_clk_en <= 1'b1;
      if (ev_por) begin
        phy_por        <= 1'b1;
        host_rst_n     <= 1'b0;
        phy_port_rst_n <= 1'b0;
        hdiv_rst_n     <= 1'b0;
        odiv_rst_n     <= 1'b0;
        hdiv_en        <= 1'b0;
        odiv_en        <= 1'b0;
      end
      if (ev_hen)  hdiv_en        <= 1'b1;
      if (ev_hrel) hdiv_rst_n     <= 1'b1;
      if (ev_porx) phy_por        <= 1'b0;
      if (ev_ton)  phy_test_rst   <= 1'b1;
      if (ev_toff) phy_test_rst   <= 1'b0;
      if (ev_orel) odiv_rst_n     <= 1'b1;
      if (ev_oen)  odiv_en        <= 1'b1;
      if (ev_prel) phy_port_rst_n <= 1'b1;
      if (ev_host) begin
        host_rst_n <= 1'b1;
        seq_done   <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/usb_rst_seq_chk.sv
module usb_rst_seq_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk_io,
  input logic             rst_n,
  input logic             start_req,
  input logic             stop_req,
  input logic             if_clk_en,
  input logic             phy_por,
  input logic             phy_test_rst,
  input logic             phy_port_rst_n,
  input logic             hdiv_rst_n,
  input logic             hdiv_en,
  input logic             odiv_rst_n,
  input logic             odiv_en,
  input logic             host_rst_n,
  input logic [1:0]       refclk_div,
  input logic [3:0]       host_div,
  input logic             rate_err,
  input logic             seq_done,
  input logic [CNT_W-1:0] user_cnt
);

  p_ifen_hold_r2: assert property (@(posedge clk_io) disable iff (!rst_n)
    if_clk_en |=> if_clk_en);

  p_por_clean_r3: assert property (@(posedge clk_io) disable iff (!rst_n)
    $rose(phy_por) |-> (if_clk_en && !host_rst_n && !phy_port_rst_n && !hdiv_rst_n
                        && !hdiv_en && !odiv_rst_n && !odiv_en));

  p_err_code_r4: assert property (@(posedge clk_io) disable iff (!rst_n)
    rate_err |-> (refclk_div == 2'd0));

  p_div_legal_r5: assert property (@(posedge clk_io) disable iff (!rst_n)
    seq_done |-> (host_div inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd6, 4'd8, 4'd12}));

  p_hdiv_order_r6: assert property (@(posedge clk_io) disable iff (!rst_n)
    $rose(hdiv_rst_n) |-> (hdiv_en && $past(hdiv_en)));

  p_test_window_r7: assert property (@(posedge clk_io) disable iff (!rst_n)
    phy_test_rst |-> (!phy_por && hdiv_rst_n && !odiv_rst_n));

  p_odiv_order_r8: assert property (@(posedge clk_io) disable iff (!rst_n)
    $rose(odiv_en) |-> (odiv_rst_n && $past(odiv_rst_n)));

  p_host_last_r9: assert property (@(posedge clk_io) disable iff (!rst_n)
    $rose(host_rst_n) |-> (phy_port_rst_n && odiv_en && !phy_por && seq_done));

  p_cnt_dec_r10: assert property (@(posedge clk_io) disable iff (!rst_n)
    (stop_req && !start_req && user_cnt != '0) |=> (user_cnt == $past(user_cnt) - 1'b1));

  p_host_hold_r11: assert property (@(posedge clk_io) disable iff (!rst_n)
    host_rst_n |=> host_rst_n);

  p_done_hold_r11: assert property (@(posedge clk_io) disable iff (!rst_n)
    seq_done |=> seq_done);

endmodule

bind usb_rst_seq usb_rst_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_io         (clk_io),
  .rst_n          (rst_n),
  .start_req      (start_req),
  .stop_req       (stop_req),
  .if_clk_en      (if_clk_en),
  .phy_por        (phy_por),
  .phy_test_rst   (phy_test_rst),
  .phy_port_rst_n (phy_port_rst_n),
  .hdiv_rst_n     (hdiv_rst_n),
  .hdiv_en        (hdiv_en),
  .odiv_rst_n     (odiv_rst_n),
  .odiv_en        (odiv_en),
  .host_rst_n     (host_rst_n),
  .refclk_div     (refclk_div),
  .host_div       (host_div),
  .rate_err       (rate_err),
  .seq_done       (seq_done),
  .user_cnt       (user_cnt)
);

// File: tb/usb_rst_seq_test.sv
module usb_rst_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int P_DIV  = 64;
  localparam int P_1MS  = 200;
  localparam int P_1US  = 20;
  localparam int P_10NS = 3;
  localparam int P_20NS = 5;
  localparam int CMAXV  = 15;

  logic       clk_io = 1'b0;
  logic       rst_n;
  logic       start_req, stop_req;
  logic [7:0] ref_mhz;
  logic       ref_xtal;
  logic [7:0] io_ratio;
  logic       if_clk_en, phy_por, phy_test_rst, phy_port_rst_n;
  logic       hdiv_rst_n, hdiv_en, odiv_rst_n, odiv_en, host_rst_n;
  logic       refclk_sel, rate_err, seq_done;
  logic [1:0] refclk_div;
  logic [3:0] host_div;
  logic [3:0] user_cnt;

  int nchk = 0;
  int nfail = 0;
  int model_cnt = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_io = ~clk_io;

  usb_rst_seq #(
    .RATE_W(8), .RATIO_W(8), .CNT_W(4), .DIV_WAIT(P_DIV),
    .CYC_1MS(P_1MS), .CYC_1US(P_1US), .CYC_10NS(P_10NS), .CYC_20NS(P_20NS)
  ) uut (
    .clk_io(clk_io), .rst_n(rst_n), .start_req(start_req), .stop_req(stop_req),
    .ref_mhz(ref_mhz), .ref_xtal(ref_xtal), .io_ratio(io_ratio),
    .if_clk_en(if_clk_en), .phy_por(phy_por), .phy_test_rst(phy_test_rst),
    .phy_port_rst_n(phy_port_rst_n), .hdiv_rst_n(hdiv_rst_n), .hdiv_en(hdiv_en),
    .odiv_rst_n(odiv_rst_n), .odiv_en(odiv_en), .host_rst_n(host_rst_n),
    .refclk_sel(refclk_sel), .refclk_div(refclk_div), .host_div(host_div),
    .rate_err(rate_err), .seq_done(seq_done), .user_cnt(user_cnt)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int exp_hdiv(input int r);
    if (r == 0)      return 1;
    else if (r < 5)  return r;
    else if (r == 5) return 4;
    else if (r < 8)  return 6;
    else if (r < 12) return 8;
    return 12;
  endfunction

  function automatic int exp_rdiv(input int m);
    return (m == 24) ? 1 : (m == 48) ? 2 : 0;
  endfunction

  function automatic int exp_err(input int m);
    return (m == 12 || m == 24 || m == 48) ? 0 : 1;
  endfunction

  function automatic int next_cnt(input int c, input bit s, input bit p);
    if (s && !p) return (c < CMAXV) ? c + 1 : c;
    if (p && !s) return (c > 0) ? c - 1 : c;
    return c;
  endfunction

  task automatic drive(input bit s, input bit p);
    start_req = s;
    stop_req  = p;
    model_cnt = next_cnt(model_cnt, s, p);
    @(negedge clk_io);
  endtask

  task automatic check_all_static(input string req, input int hd, input int rd, input int er,
                                  input int sel);
    chk(req, "if_clk_en", int'(if_clk_en), 1);
    chk(req, "phy_por", int'(phy_por), 0);
    chk(req, "phy_test_rst", int'(phy_test_rst), 0);
    chk(req, "phy_port_rst_n", int'(phy_port_rst_n), 1);
    chk(req, "hdiv_en", int'(hdiv_en), 1);
    chk(req, "hdiv_rst_n", int'(hdiv_rst_n), 1);
    chk(req, "odiv_en", int'(odiv_en), 1);
    chk(req, "odiv_rst_n", int'(odiv_rst_n), 1);
    chk(req, "host_rst_n", int'(host_rst_n), 1);
    chk(req, "seq_done", int'(seq_done), 1);
    chk(req, "host_div", int'(host_div), hd);
    chk(req, "refclk_div", int'(refclk_div), rd);
    chk(req, "rate_err", int'(rate_err), er);
    chk(req, "refclk_sel", int'(refclk_sel), sel);
  endtask

  task automatic run_seq(input int ratio, input int mhz, input bit xtal, input bit noise,
                         input bit extras);
    int t_porx, t_ton, t_toff, t_orel, t_oen, t_prel, t_host;
    int ehd, erd, eer, esel;
    t_porx = 6 + P_DIV;
    t_ton  = t_porx + P_1MS;
    t_toff = t_ton + P_10NS;
    t_orel = t_toff + P_20NS;
    t_oen  = t_orel + 1;
    t_prel = t_oen + P_DIV;
    t_host = t_prel + P_1US;
    ehd  = exp_hdiv(ratio);
    erd  = exp_rdiv(mhz);
    eer  = exp_err(mhz);
    esel = xtal ? 0 : 1;

    io_ratio  = 8'(ratio);
    ref_mhz   = 8'(mhz);
    ref_xtal  = xtal;
    start_req = 1'b0;
    stop_req  = 1'b0;
    rst_n     = 1'b0;
    model_cnt = 0;
    repeat (3) @(negedge clk_io);
    // R1: reset state
    chk("R1", "if_clk_en", int'(if_clk_en), 0);
    chk("R1", "phy_por", int'(phy_por), 0);
    chk("R1", "host_rst_n", int'(host_rst_n), 0);
    chk("R1", "seq_done", int'(seq_done), 0);
    chk("R1", "host_div", int'(host_div), 0);
    chk("R1", "rate_err", int'(rate_err), 0);
    chk("R1", "user_cnt", int'(user_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk_io);
    chk("R1", "odiv_en after release", int'(odiv_en), 0);

    drive(1'b1, 1'b0);   // start edge is cycle 0
    for (int k = 0; k <= t_host + 3; k++) begin
      bit s, p;
      chk("R2", "if_clk_en", int'(if_clk_en), 1);
      chk("R3", "phy_por", int'(phy_por), (k >= 2 && k < t_porx) ? 1 : 0);
      chk("R4", "refclk_sel", int'(refclk_sel), (k >= 3) ? esel : 0);
      chk("R4", "refclk_div", int'(refclk_div), (k >= 3) ? erd : 0);
      chk("R4", "rate_err", int'(rate_err), (k >= 3) ? eer : 0);
      chk("R5", "host_div", int'(host_div), (k >= 4) ? ehd : 0);
      chk("R6", "hdiv_en", int'(hdiv_en), (k >= 5) ? 1 : 0);
      chk("R6", "hdiv_rst_n", int'(hdiv_rst_n), (k >= 6) ? 1 : 0);
      chk("R7", "phy_test_rst", int'(phy_test_rst), (k >= t_ton && k < t_toff) ? 1 : 0);
      chk("R7", "odiv_rst_n", int'(odiv_rst_n), (k >= t_orel) ? 1 : 0);
      chk("R8", "odiv_en", int'(odiv_en), (k >= t_oen) ? 1 : 0);
      chk("R8", "phy_port_rst_n", int'(phy_port_rst_n), (k >= t_prel) ? 1 : 0);
      chk("R9", "host_rst_n", int'(host_rst_n), (k >= t_host) ? 1 : 0);
      chk("R9", "seq_done", int'(seq_done), (k >= t_host) ? 1 : 0);
      chk("R10", "user_cnt", int'(user_cnt), model_cnt);
      s = 1'b0;
      p = 1'b0;
      if (k == 10) s = 1'b1;            // R12: start while busy
      else if (k == 20) p = 1'b1;
      else if (noise) begin
        s = ($urandom % 8) == 0;
        p = ($urandom % 8) == 0;
      end
      drive(s, p);
    end

    // R11: stops down to zero leave every output alone
    while (model_cnt > 0) drive(1'b0, 1'b1);
    drive(1'b0, 1'b1);
    chk("R10", "user_cnt floor", int'(user_cnt), 0);
    check_all_static("R11", ehd, erd, eer, esel);

    // R13: start with host already released skips the sequence
    drive(1'b1, 1'b0);
    repeat (4) drive(1'b0, 1'b0);
    chk("R13", "user_cnt", int'(user_cnt), 1);
    check_all_static("R13", ehd, erd, eer, esel);

    if (extras) begin
      drive(1'b1, 1'b1);
      chk("R10", "same-cycle start/stop", int'(user_cnt), 1);
      repeat (20) drive(1'b1, 1'b0);
      chk("R10", "saturate high", int'(user_cnt), CMAXV);
      repeat (20) drive(1'b0, 1'b1);
      chk("R10", "saturate low", int'(user_cnt), 0);
      check_all_static("R11", ehd, erd, eer, esel);
    end
  endtask

  initial begin
    int ratios[12] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 11, 12, 200};
    int rates[6]   = '{12, 24, 48, 13, 0, 96};
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    start_req = 1'b0;
    stop_req = 1'b0;
    ref_mhz = 8'd12;
    ref_xtal = 1'b0;
    io_ratio = 8'd0;
    @(negedge clk_io);
    foreach (ratios[i])
      run_seq(ratios[i], rates[i % 6], i[0], 1'b0, (i == 0));
    for (int j = 0; j < 4; j++) begin
      int r, m;
      r = int'($urandom % 256);
      m = ((j % 2) == 0) ? rates[$urandom % 3] : int'($urandom % 256);
      run_seq(r, m, 1'($urandom % 2), 1'b1, 1'b0);
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_io);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

endmodule